// File: doc/BRIEF.md
# Interlocked Issue Scoreboard

This block decides, cycle by cycle, whether the instruction line presented at the issue point may leave. A line carries up to four instruction slots. Each slot names up to two source registers and one destination register, each with its own valid bit. The grouping of the slots was fixed before run time. The block keeps a record of every register that has a result still in flight. When any source or destination of the presented line hits that record, the whole line is stalled. Upstream logic holds the line unchanged until it issues.

Every result arrives a fixed `LAT` cycles after the line that produces it issues, with a default of two. A line issued in cycle i therefore makes its destinations readable in cycle i+2. The block also reports which registers are being written back in the current cycle. A stalled line produces no write-back, so the write-back stream contains only lines that issued. Results complete in issue order, because a line may not issue over a destination that is still pending.

Top module: `issue_scoreboard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `stall`, `issue`, `wb_vld` and `wb_mask` are all 0 when no line is presented.
- R2: When a line is presented and none of its operands is in flight, `issue` is 1 and `stall` is 0 in that same cycle.
- R3: A line that reads a register written by the line issued one cycle earlier has `stall` = 1 in that cycle. The same line, held unchanged, issues in the following cycle, which is two cycles after the producer issued.
- R4: A line whose destination equals a destination still in flight is stalled, even if it reads nothing.
- R5: One cycle after a line issues (LAT = 2), `wb_mask` has bit n set for each valid destination index n of that line, with no other bits set. `wb_vld` is 1 exactly when `wb_mask` is nonzero.
- R6: A cycle in which the line was stalled is followed by a cycle with `wb_vld` = 0.
- R7: An operand whose own valid bit is 0, or whose slot valid bit is 0, neither causes a stall nor appears in `wb_mask`.
- R8: With `line_vld` = 0, `stall` and `issue` are 0 whatever the slot fields hold, and the next cycle shows no write-back.
- R9: A hazard in any operand position stalls the line, including the second source of the last slot.
- R10: Only an exact index match stalls: registers next to a pending one may be read freely.
- R11: A line that reads a register written by one of its own slots is not stalled by that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | 1 | A line is presented for issue |
| slot_vld | input | 4 | Per-slot valid |
| src_vld | input | 8 | Source valid, operand k = slot k/2, position k%2 |
| src_idx | input | 40 | Source indices, operand k in bits [5k+4:5k] |
| dst_vld | input | 4 | Destination valid per slot |
| dst_idx | input | 20 | Destination index, slot s in bits [5s+4:5s] |
| stall | output | 1 | Line is present and must be held |
| issue | output | 1 | Line is present and leaves this cycle |
| wb_vld | output | 1 | At least one register is written back this cycle |
| wb_mask | output | 32 | One bit per register written back this cycle |

## Verification
Write-back of an older line and the stall or issue of a newer line fall in the same cycle. In the read-after-write and write-after-write tests, the dependent line is presented exactly one cycle after its producer issues. The bench then checks `stall` together with the producer's `wb_mask` in that cycle. The dependent line is held into the next cycle, where the bench expects `issue` together with an empty write-back, because the stalled cycle put nothing into the pipe. Back-to-back independent lines check that an issue and a write-back can occur in the same cycle.

// File: rtl/isb_pkg.sv
package isb_pkg;
   localparam int unsigned ISB_REGS  = 32;
   localparam int unsigned ISB_SLOTS = 4;
   localparam int unsigned ISB_SRCS  = 2;
   localparam int unsigned ISB_LAT   = 2;
endpackage

// File: rtl/isb_mask_dec.sv
module isb_mask_dec #(
   parameter int unsigned REGS = 32,
   parameter int unsigned N    = 4,
   parameter int unsigned IDXW = 5
) (
   input  logic [N-1:0]      vld,
   input  logic [N*IDXW-1:0] idx,
   output logic [REGS-1:0]   mask
);
   always_comb begin
      mask = '0;
      for (int k = 0; k < N; k++) begin
         if (vld[k]) mask[idx[k*IDXW +: IDXW]] = 1'b1;
      end
   end
endmodule

// File: rtl/isb_wb_pipe.sv
module isb_wb_pipe #(
   parameter int unsigned REGS = 32,
   parameter int unsigned LAT  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [REGS-1:0] in_mask,
   output logic [REGS-1:0] busy,
   output logic [REGS-1:0] wb_mask
);
   localparam int unsigned DEPTH = LAT - 1;

   generate
      if (LAT < 2) begin : g_bad_lat
         $error("isb_wb_pipe: LAT must be at least 2");
      end
      if (DEPTH == 1) begin : g_single
         logic [REGS-1:0] stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= '0;
            else        stage <= in_mask;
         end
         assign busy    = stage;
         assign wb_mask = stage;
      end else begin : g_chain
         logic [REGS-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
            end else begin
               stage[0] <= in_mask;
               for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
            end
         end
         always_comb begin
            busy = '0;
            for (int k = 0; k < DEPTH; k++) busy = busy | stage[k];
         end
         assign wb_mask = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
   parameter int unsigned REGS  = isb_pkg::ISB_REGS,
   parameter int unsigned SLOTS = isb_pkg::ISB_SLOTS,
   parameter int unsigned SRCS  = isb_pkg::ISB_SRCS,
   parameter int unsigned LAT   = isb_pkg::ISB_LAT,
   localparam int unsigned IDXW = $clog2(REGS),
   localparam int unsigned NSRC = SLOTS * SRCS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_vld,
   input  logic [SLOTS-1:0]      slot_vld,
   input  logic [NSRC-1:0]       src_vld,
   input  logic [NSRC*IDXW-1:0]  src_idx,
   input  logic [SLOTS-1:0]      dst_vld,
   input  logic [SLOTS*IDXW-1:0] dst_idx,
   output logic                  stall,
   output logic                  issue,
   output logic                  wb_vld,
   output logic [REGS-1:0]       wb_mask
);
   generate
      if ((1 << IDXW) != REGS) begin : g_bad_regs
         $error("issue_scoreboard: REGS must be a power of two");
      end
      if (SLOTS < 1 || SRCS < 1) begin : g_bad_shape
         $error("issue_scoreboard: SLOTS and SRCS must be nonzero");
      end
   endgenerate

   logic [NSRC-1:0]  src_en;
   logic [SLOTS-1:0] dst_en;
   logic [REGS-1:0]  src_mask, dst_mask, busy, pipe_in;
   logic             hazard;

   for (genvar k = 0; k < NSRC; k++) begin : g_src_en
      assign src_en[k] = src_vld[k] & slot_vld[k / SRCS];
   end
   assign dst_en = dst_vld & slot_vld;

   isb_mask_dec #(.REGS(REGS), .N(NSRC), .IDXW(IDXW)) u_src_dec (
      .vld(src_en), .idx(src_idx), .mask(src_mask)
   );
   isb_mask_dec #(.REGS(REGS), .N(SLOTS), .IDXW(IDXW)) u_dst_dec (
      .vld(dst_en), .idx(dst_idx), .mask(dst_mask)
   );

   assign hazard  = |((src_mask | dst_mask) & busy);
   assign stall   = line_vld & hazard;
   assign issue   = line_vld & ~hazard;
   assign pipe_in = issue ? dst_mask : '0;

   isb_wb_pipe #(.REGS(REGS), .LAT(LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .in_mask(pipe_in),
      .busy(busy), .wb_mask(wb_mask)
   );

   assign wb_vld = |wb_mask;
endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
   parameter int unsigned SLOTS = 4,
   parameter int unsigned LAT   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_vld,
   input logic [SLOTS-1:0] slot_vld,
   input logic [SLOTS-1:0] dst_vld,
   input logic             stall,
   input logic             issue,
   input logic             wb_vld
);
   a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall && issue));

   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !line_vld |-> (!stall && !issue));

   generate
      if (LAT == 2) begin : g_lat2
         a_r5_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && |(dst_vld & slot_vld)) |=> wb_vld);
         a_r5_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
            !issue |=> !wb_vld);
         a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
            stall |=> !wb_vld);
      end
   endgenerate
endmodule

bind issue_scoreboard isb_checker #(.SLOTS(SLOTS), .LAT(LAT)) u_isb_checker (
   .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .slot_vld(slot_vld),
   .dst_vld(dst_vld), .stall(stall), .issue(issue), .wb_vld(wb_vld)
);

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_vld = 1'b0;
   logic [3:0]  slot_vld = '0;
   logic [7:0]  src_vld = '0;
   logic [39:0] src_idx = '0;
   logic [3:0]  dst_vld = '0;
   logic [19:0] dst_idx = '0;
   logic        stall, issue, wb_vld;
   logic [31:0] wb_mask;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   issue_scoreboard i_issue_scoreboard (
      .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .slot_vld(slot_vld),
      .src_vld(src_vld), .src_idx(src_idx), .dst_vld(dst_vld), .dst_idx(dst_idx),
      .stall(stall), .issue(issue), .wb_vld(wb_vld), .wb_mask(wb_mask)
   );

   task automatic chk1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chkm(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_line();
      line_vld = 0; slot_vld = '0; src_vld = '0; src_idx = '0; dst_vld = '0; dst_idx = '0;
   endtask

   task automatic set_slot(input int s, input int a, input bit av,
                           input int b, input bit bv, input int d, input bit dv);
      slot_vld[s] = 1'b1;
      src_idx[(s*2)*5 +: 5]   = a[4:0]; src_vld[s*2]   = av;
      src_idx[(s*2+1)*5 +: 5] = b[4:0]; src_vld[s*2+1] = bv;
      dst_idx[s*5 +: 5] = d[4:0]; dst_vld[s] = dv;
   endtask

   // advance one clock; inputs change after the falling edge, checks 1 unit later
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic producer(input int d);
      clear_line(); line_vld = 1; set_slot(0, 0, 0, 0, 0, d, 1);
      #1;
      chk1("R2 producer issues", issue, 1'b1);
      step();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      #1;
      chk1("R1 stall in reset", stall, 1'b0);
      chk1("R1 wb_vld in reset", wb_vld, 1'b0);
      @(negedge clk); rst_n = 1; #1;
      chk1("R1 issue after reset", issue, 1'b0);
      chkm("R1 wb_mask after reset", wb_mask, 32'h0);
      step();
      chk1("R1 stall first cycle", stall, 1'b0);
      chk1("R1 wb_vld first cycle", wb_vld, 1'b0);
   endtask

   task automatic t_basic();
      clear_line(); line_vld = 1;
      set_slot(0, 1, 1, 2, 1, 3, 1);
      set_slot(2, 0, 0, 0, 0, 7, 1);
      #1;
      chk1("R2 issue", issue, 1'b1);
      chk1("R2 stall", stall, 1'b0);
      // back-to-back independent line
      step();
      chkm("R5 wb mask", wb_mask, (32'h1 << 3) | (32'h1 << 7));
      chk1("R5 wb_vld", wb_vld, 1'b1);
      clear_line(); line_vld = 1; set_slot(1, 8, 1, 0, 0, 9, 1); #1;
      chk1("R2 issue during write-back", issue, 1'b1);
      step();
      chkm("R5 wb second line", wb_mask, 32'h1 << 9);
      clear_line();
      step();
      chk1("R5 wb once only", wb_vld, 1'b0);
   endtask

   task automatic t_raw();
      producer(10);
      clear_line(); line_vld = 1; set_slot(1, 10, 1, 0, 0, 11, 1); #1;
      chk1("R3 stall on read", stall, 1'b1);
      chk1("R3 no issue", issue, 1'b0);
      chkm("R5 producer write-back with stall", wb_mask, 32'h1 << 10);
      step();
      chk1("R3 held line issues", issue, 1'b1);
      chk1("R6 bubble after stall", wb_vld, 1'b0);
      step();
      clear_line(); #1;
      chkm("R5 dependent write-back", wb_mask, 32'h1 << 11);
      step();
   endtask

   task automatic t_waw();
      producer(20);
      clear_line(); line_vld = 1; set_slot(2, 0, 0, 0, 0, 20, 1); #1;
      chk1("R4 stall on pending dest", stall, 1'b1);
      step();
      chk1("R4 issue after drain", issue, 1'b1);
      step();
      clear_line(); #1;
      chkm("R4 second write", wb_mask, 32'h1 << 20);
      step();
   endtask

   task automatic t_ignore();
      producer(15);
      clear_line(); line_vld = 1;
      set_slot(0, 15, 1, 0, 0, 16, 1); slot_vld[0] = 0;
      set_slot(1, 15, 0, 0, 0, 15, 0);
      set_slot(2, 0, 0, 0, 0, 17, 1);
      #1;
      chk1("R7 invalid operands ignored", issue, 1'b1);
      step();
      clear_line(); #1;
      chkm("R7 only valid dest written", wb_mask, 32'h1 << 17);
      step();
   endtask

   task automatic t_idle();
      producer(9);
      clear_line(); set_slot(0, 9, 1, 9, 1, 9, 1); line_vld = 0; #1;
      chk1("R8 no stall when idle", stall, 1'b0);
      chk1("R8 no issue when idle", issue, 1'b0);
      step();
      chk1("R8 no write-back", wb_vld, 1'b0);
      clear_line();
      step();
   endtask

   task automatic t_slot3();
      producer(25);
      clear_line(); line_vld = 1;
      set_slot(0, 1, 1, 2, 1, 3, 1);
      set_slot(3, 4, 1, 25, 1, 6, 1);
      #1;
      chk1("R9 last operand stalls", stall, 1'b1);
      step();
      chk1("R9 issue after drain", issue, 1'b1);
      step();
      clear_line();
      step();
   endtask

   task automatic t_neighbour();
      producer(5);
      clear_line(); line_vld = 1; set_slot(0, 4, 1, 6, 1, 7, 1); #1;
      chk1("R10 neighbours free", issue, 1'b1);
      chkm("R10 pending write-back", wb_mask, 32'h1 << 5);
      step();
      clear_line(); #1;
      chkm("R10 write-back", wb_mask, 32'h1 << 7);
      step();
   endtask

   task automatic t_intra();
      clear_line(); line_vld = 1;
      set_slot(0, 12, 1, 0, 0, 13, 1);
      set_slot(1, 13, 1, 0, 0, 12, 1);
      #1;
      chk1("R11 own-line read", issue, 1'b1);
      step();
      clear_line(); #1;
      chkm("R11 write-back", wb_mask, (32'h1 << 12) | (32'h1 << 13));
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_basic();
      t_raw();
      t_waw();
      t_ignore();
      t_idle();
      t_slot3();
      t_neighbour();
      t_intra();
      finish_run();
   end
endmodule